// File: doc/BRIEF.md
# Display-Side Link Frame Decoder and Parallel Bus Regenerator

This block sits next to one or two display panels at the far end of a two-lane serial link. It samples both data lanes once per bit slot, recognises command frames, and rebuilds a CPU-style (i80) parallel bus from them. That bus has a 16-bit data output, an address/data select, two active-low chip selects and active-low write and read strobes. The master side sends data on both clock edges, so one bit slot is half a link-clock cycle. The block's clock `clk_i` runs at the slot rate, and `LINK_DIV` slots make one link cycle.

A write frame updates the data, A/D and chip-select outputs and then pulses the write strobe for a fixed number of link cycles. A read frame works in three steps:

- The block takes over the lanes and holds them high.
- It strobes the panel once, or twice when a dummy read is requested.
- It returns the captured 16-bit word at the slower single-edge rate, which is one bit per link cycle per lane, led by a low start bit and followed by a high tail bit. It then releases the lanes.

Between transactions, every bus output keeps its last value.

Frame layout, one slot per bit. While idle, lane 0 rests high. A frame begins when lane 0 falls from high to low:

| Slot | Lane 0 | Lane 1 |
|------|--------|--------|
| 0 | start bit (low) | direction: 1 = read, 0 = write |
| 1 | A/D | chip-select bit |
| 2 to 9 (writes only) | data bits 0 to 7, LSB first | data bits 8 to 15, LSB first |

Top module: `sfd_slave_top`

## Requirements
- R1: While rst_ni is low (power-down or power-up), dat_o is all zeros, ad_o, cs1_no, cs2_no, wr_no and rd_no are high, lane_oe_o is low and frame_cnt_o is zero.
- R2: A write frame puts the 16 data bits on dat_o, with lane 0 slots 2 to 9 forming bits 0 to 7 and lane 1 slots 2 to 9 forming bits 8 to 15, LSB first.
- R3: Every frame copies its slot-1 lane-0 bit to ad_o. A chip-select bit of 1 drives cs1_no low and cs2_no high; a 0 does the reverse. Both chip selects are never low together.
- R4: Each write frame produces exactly one write-strobe pulse, low for STROBE_LINK link cycles (6 clk_i cycles by default), whatever the master saw.
- R5: After a transaction, dat_o, ad_o and the active chip select hold their values until a later frame changes them. A read frame leaves dat_o unchanged.
- R6: A read frame causes two read-strobe pulses when idr_i is high at the frame, and one pulse when idr_i is low.
- R7: After a read header, lane_oe_o goes high with lane_o = 2'b11 within 14 clk_i edges. rd_no is low only while lane_oe_o is high.
- R8: Read return is a start bit of 2'b00 for one link cycle, then 8 link cycles where lane_o[0] carries bit k and lane_o[1] carries bit 8+k of the word, for k = 0 to 7. The word is rd_data_i sampled at the rising edge of the last read strobe.
- R9: After the data bits, lane_o is 2'b11 for one link cycle and then lane_oe_o drops.
- R10: frame_cnt_o increments by exactly one for every decoded frame, read or write. No frame is discarded.
- R11: Each read-strobe pulse is low for STROBE_LINK link cycles.
- R12: A new frame starts only on a high-to-low transition of lane 0 while idle. Lane 0 held low after a frame starts nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bit-slot clock (LINK_DIV per link cycle) |
| rst_ni | input | 1 | Active-low asynchronous reset / power-down |
| lane_i | input | 2 | Sampled serial data lanes from the master |
| idr_i | input | 1 | Insert dummy read when high |
| rd_data_i | input | 16 | Read data from the panel |
| lane_o | output | 2 | Lane values driven back during reads |
| lane_oe_o | output | 1 | Lane drive enable |
| dat_o | output | 16 | Regenerated parallel data |
| ad_o | output | 1 | Address/data select |
| cs1_no | output | 1 | Chip select 1, active low |
| cs2_no | output | 1 | Chip select 2, active low |
| wr_no | output | 1 | Write strobe, active low |
| rd_no | output | 1 | Read strobe, active low |
| frame_cnt_o | output | 8 | Decoded frame counter |

## Verification
The bench sends the dummy read with a different word on the panel bus during the first strobe than during the second. A design that returned the dummy word, or that issued the wrong number of strobes, would show a wrong returned word or a wrong pulse count. The bench measures every strobe width in clock cycles, so a counter that is off by one shows up at once. It also rebuilds the returned word bit by bit from the lanes, which exposes swapped lanes or a shifted bit order. It holds lane 0 low after a frame whose final bit is zero, so edge detection that was really level detection would decode phantom frames.

// File: rtl/sfd_pkg.sv
package sfd_pkg;
  localparam int STB_WR = 0;
  localparam int STB_RD = 1;

  typedef struct packed {
    logic rw;
    logic ad;
    logic csel;
  } cmd_t;

  typedef enum logic [1:0] {DF_IDLE, DF_HDR, DF_DATA} deframe_e;
  typedef enum logic [1:0] {SQ_IDLE, SQ_RD, SQ_GAP, SQ_TX} seq_e;
  typedef enum logic [2:0] {TX_OFF, TX_HOLD, TX_START, TX_DATA, TX_TAIL} tx_e;
endpackage

// File: rtl/sfd_deframe.sv
module sfd_deframe
  import sfd_pkg::*;
#(
  parameter int HALF_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [1:0]          lane_i,
  input  logic                busy_i,
  output logic                cmd_valid_o,
  output cmd_t                cmd_o,
  output logic                wr_valid_o,
  output logic [2*HALF_W-1:0] wr_data_o
);
  localparam int CW = (HALF_W > 1) ? $clog2(HALF_W) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_W - 1);

  deframe_e          st_q;
  logic              prev_q, rw_q;
  logic [CW-1:0]     cnt_q;
  logic [HALF_W-1:0] lo_q, hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= DF_IDLE;
      prev_q      <= 1'b1;
      rw_q        <= 1'b0;
      cnt_q       <= '0;
      lo_q        <= '0;
      hi_q        <= '0;
      cmd_valid_o <= 1'b0;
      cmd_o       <= '0;
      wr_valid_o  <= 1'b0;
    end else begin
      prev_q      <= lane_i[0];
      cmd_valid_o <= 1'b0;
      wr_valid_o  <= 1'b0;
      case (st_q)
        DF_IDLE: begin
          // start = falling edge on lane 0, never a held low
          if (!busy_i && prev_q && !lane_i[0]) begin
            rw_q <= lane_i[1];
            st_q <= DF_HDR;
          end
        end
        DF_HDR: begin
          cmd_o       <= '{rw: rw_q, ad: lane_i[0], csel: lane_i[1]};
          cmd_valid_o <= 1'b1;
          cnt_q       <= '0;
          st_q        <= rw_q ? DF_IDLE : DF_DATA;
        end
        DF_DATA: begin
          lo_q  <= {lane_i[0], lo_q[HALF_W-1:1]};
          hi_q  <= {lane_i[1], hi_q[HALF_W-1:1]};
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == LAST) begin
            wr_valid_o <= 1'b1;
            st_q       <= DF_IDLE;
          end
        end
        default: st_q <= DF_IDLE;
      endcase
    end
  end

  assign wr_data_o = {hi_q, lo_q};
endmodule

// File: rtl/sfd_strobe.sv
module sfd_strobe #(
  parameter int LOW_CYC = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic strobe_no,
  output logic rel_o
);
  localparam int CW = (LOW_CYC > 1) ? $clog2(LOW_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(LOW_CYC - 1);

  logic          low_q;
  logic [CW-1:0] cnt_q;

  // high in the cycle whose closing edge releases the strobe
  assign rel_o     = low_q && (cnt_q == LAST);
  assign strobe_no = ~low_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      low_q <= 1'b0;
      cnt_q <= '0;
    end else if (start_i) begin
      low_q <= 1'b1;
      cnt_q <= '0;
    end else if (low_q) begin
      if (rel_o) low_q <= 1'b0;
      else       cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/sfd_ret_tx.sv
module sfd_ret_tx
  import sfd_pkg::*;
#(
  parameter int HALF_W   = 8,
  parameter int LINK_DIV = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                turn_i,
  input  logic                send_i,
  input  logic [2*HALF_W-1:0] data_i,
  output logic [1:0]          lane_o,
  output logic                oe_o,
  output logic                done_o
);
  localparam int DVW = (LINK_DIV > 1) ? $clog2(LINK_DIV) : 1;
  localparam int BW  = (HALF_W > 1) ? $clog2(HALF_W) : 1;
  localparam logic [DVW-1:0] DIV_LAST = DVW'(LINK_DIV - 1);
  localparam logic [BW-1:0]  BIT_LAST = BW'(HALF_W - 1);

  tx_e               st_q;
  logic [DVW-1:0]    div_q;
  logic [BW-1:0]     bit_q;
  logic [HALF_W-1:0] lo_q, hi_q;
  logic              slot_end;

  assign slot_end = (div_q == DIV_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= TX_OFF;
      div_q  <= '0;
      bit_q  <= '0;
      lo_q   <= '0;
      hi_q   <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      div_q  <= slot_end ? '0 : div_q + 1'b1;
      case (st_q)
        TX_OFF:  if (turn_i) st_q <= TX_HOLD;
        TX_HOLD: if (send_i) begin
          lo_q  <= data_i[HALF_W-1:0];
          hi_q  <= data_i[2*HALF_W-1:HALF_W];
          div_q <= '0;
          bit_q <= '0;
          st_q  <= TX_START;
        end
        TX_START: if (slot_end) st_q <= TX_DATA;
        TX_DATA: if (slot_end) begin
          bit_q <= bit_q + 1'b1;
          if (bit_q == BIT_LAST) st_q <= TX_TAIL;
        end
        TX_TAIL: if (slot_end) begin
          st_q   <= TX_OFF;
          done_o <= 1'b1;
        end
        default: st_q <= TX_OFF;
      endcase
    end
  end

  always_comb begin
    oe_o   = (st_q != TX_OFF);
    lane_o = 2'b11;
    case (st_q)
      TX_OFF:   lane_o = 2'b00;
      TX_START: lane_o = 2'b00;
      TX_DATA:  lane_o = {hi_q[bit_q], lo_q[bit_q]};
      default:  lane_o = 2'b11;
    endcase
  end
endmodule

// File: rtl/sfd_slave_top.sv
module sfd_slave_top
  import sfd_pkg::*;
#(
  parameter int HALF_W      = 8,
  parameter int LINK_DIV    = 2,
  parameter int STROBE_LINK = 3,
  parameter int FCNT_W      = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [1:0]          lane_i,
  input  logic                idr_i,
  input  logic [2*HALF_W-1:0] rd_data_i,
  output logic [1:0]          lane_o,
  output logic                lane_oe_o,
  output logic [2*HALF_W-1:0] dat_o,
  output logic                ad_o,
  output logic                cs1_no,
  output logic                cs2_no,
  output logic                wr_no,
  output logic                rd_no,
  output logic [FCNT_W-1:0]   frame_cnt_o
);
  localparam int DW         = 2 * HALF_W;
  localparam int STROBE_CYC = STROBE_LINK * LINK_DIV;

  cmd_t          cmd;
  logic          cmd_valid, wr_valid, busy;
  logic [DW-1:0] wr_data, rd_buf_q;
  seq_e          sq_q;
  logic [1:0]    left_q, go_q, strb_n, rel;
  logic          turn_q, send_q, tx_done;

  assign busy = (sq_q != SQ_IDLE) || (cmd_valid && cmd.rw);

  sfd_deframe #(.HALF_W(HALF_W)) u_deframe (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .lane_i     (lane_i),
    .busy_i     (busy),
    .cmd_valid_o(cmd_valid),
    .cmd_o      (cmd),
    .wr_valid_o (wr_valid),
    .wr_data_o  (wr_data)
  );

  for (genvar g = 0; g < 2; g++) begin : g_strobe
    sfd_strobe #(.LOW_CYC(STROBE_CYC)) u_strobe (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .start_i  (go_q[g]),
      .strobe_no(strb_n[g]),
      .rel_o    (rel[g])
    );
  end

  assign wr_no = strb_n[STB_WR];
  assign rd_no = strb_n[STB_RD];

  sfd_ret_tx #(.HALF_W(HALF_W), .LINK_DIV(LINK_DIV)) u_ret_tx (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .turn_i(turn_q),
    .send_i(send_q),
    .data_i(rd_buf_q),
    .lane_o(lane_o),
    .oe_o  (lane_oe_o),
    .done_o(tx_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sq_q        <= SQ_IDLE;
      left_q      <= '0;
      go_q        <= '0;
      turn_q      <= 1'b0;
      send_q      <= 1'b0;
      rd_buf_q    <= '0;
      dat_o       <= '0;
      ad_o        <= 1'b1;
      cs1_no      <= 1'b1;
      cs2_no      <= 1'b1;
      frame_cnt_o <= '0;
    end else begin
      go_q   <= '0;
      turn_q <= 1'b0;
      send_q <= 1'b0;
      case (sq_q)
        SQ_RD: if (rel[STB_RD]) begin
          // capture on the rising edge of the read strobe
          rd_buf_q <= rd_data_i;
          if (left_q == 2'd1) begin
            send_q <= 1'b1;
            sq_q   <= SQ_TX;
          end else begin
            left_q <= left_q - 1'b1;
            sq_q   <= SQ_GAP;
          end
        end
        SQ_GAP: begin
          go_q[STB_RD] <= 1'b1;
          sq_q         <= SQ_RD;
        end
        SQ_TX:   if (tx_done) sq_q <= SQ_IDLE;
        default: ;
      endcase
      if (cmd_valid) begin
        frame_cnt_o <= frame_cnt_o + 1'b1;
        ad_o        <= cmd.ad;
        cs1_no      <= ~cmd.csel;
        cs2_no      <= cmd.csel;
        if (cmd.rw) begin
          sq_q         <= SQ_RD;
          left_q       <= idr_i ? 2'd2 : 2'd1;
          go_q[STB_RD] <= 1'b1;
          turn_q       <= 1'b1;
        end
      end
      if (wr_valid) begin
        dat_o        <= wr_data;
        go_q[STB_WR] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/sfd_slave_chk.sv
module sfd_slave_chk #(
  parameter int STROBE_CYC = 6,
  parameter int FCNT_W     = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [1:0]        lane_o,
  input logic              lane_oe_o,
  input logic              cs1_no,
  input logic              cs2_no,
  input logic              wr_no,
  input logic              rd_no,
  input logic [FCNT_W-1:0] frame_cnt_o
);
  logic [15:0] wr_low_q, rd_low_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_low_q <= '0;
      rd_low_q <= '0;
    end else begin
      wr_low_q <= wr_no ? '0 : wr_low_q + 1'b1;
      rd_low_q <= rd_no ? '0 : rd_low_q + 1'b1;
    end
  end

  // R3
  cs_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs1_no || cs2_no);

  // R4
  wr_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wr_no) |-> (wr_low_q == 16'(STROBE_CYC)));

  // R11
  rd_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rd_no) |-> (rd_low_q == 16'(STROBE_CYC)));

  // R7
  rd_turn_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_no |-> lane_oe_o);

  // R9
  oe_tail_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(lane_oe_o) |-> ($past(lane_o) == 2'b11));

  // R10
  fcnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_cnt_o != $past(frame_cnt_o)) |->
      (frame_cnt_o == FCNT_W'($past(frame_cnt_o) + 1'b1)));
endmodule

bind sfd_slave_top sfd_slave_chk #(
  .STROBE_CYC(STROBE_LINK * LINK_DIV),
  .FCNT_W    (FCNT_W)
) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .lane_o     (lane_o),
  .lane_oe_o  (lane_oe_o),
  .cs1_no     (cs1_no),
  .cs2_no     (cs2_no),
  .wr_no      (wr_no),
  .rd_no      (rd_no),
  .frame_cnt_o(frame_cnt_o)
);

// File: tb/sfd_slave_top_tb_top.sv
module sfd_slave_top_tb_top;
  localparam int LINK_DIV = 2;
  localparam int STB_CYC  = 6;
  localparam logic [15:0] DUMMY = 16'hDEAD;
  // vector: {rw, ad, csel, idr, data}
  localparam int NV = 8;
  localparam logic [19:0] VEC [NV] = '{
    {4'b0110, 16'hA5C3}, {4'b0000, 16'h0001}, {4'b1110, 16'h8000},
    {4'b1001, 16'hBEEF}, {4'b0100, 16'hFFFF}, {4'b1111, 16'h1234},
    {4'b0010, 16'h0000}, {4'b1000, 16'h5A69}};

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [1:0]  lane_i = 2'b11;
  logic        idr = 1'b0;
  logic [15:0] rd_data;
  logic [1:0]  lane_o;
  logic        lane_oe, ad, cs1_n, cs2_n, wr_n, rd_n;
  logic [15:0] dat;
  logic [7:0]  fcnt;

  int checks = 0, errors = 0;
  int wr_run = 0, rd_run = 0, wr_last = 0, rd_last = 0, wr_pulses = 0, rd_pulses = 0;
  int rd_base = 0;
  bit finished = 0;
  logic        cur_idr = 1'b0;
  logic [15:0] cur_rdata = 16'h0;
  logic [15:0] exp_dat = 16'h0;
  logic [7:0]  exp_fcnt = 8'h0;

  assign rd_data = (cur_idr && rd_pulses == rd_base) ? DUMMY : cur_rdata;

  always #10 clk = ~clk;

  sfd_slave_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .lane_i(lane_i), .idr_i(idr), .rd_data_i(rd_data),
    .lane_o(lane_o), .lane_oe_o(lane_oe), .dat_o(dat), .ad_o(ad), .cs1_no(cs1_n),
    .cs2_no(cs2_n), .wr_no(wr_n), .rd_no(rd_n), .frame_cnt_o(fcnt));

  always @(negedge clk) begin
    if (!wr_n) wr_run++;
    else if (wr_run != 0) begin wr_last = wr_run; wr_run = 0; wr_pulses++; end
    if (!rd_n) rd_run++;
    else if (rd_run != 0) begin rd_last = rd_run; rd_run = 0; rd_pulses++; end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic send_hdr(input logic rw, input logic a, input logic cs);
    @(negedge clk) lane_i = {rw, 1'b0};
    @(negedge clk) lane_i = {cs, a};
  endtask

  task automatic send_write(input logic a, input logic cs, input logic [15:0] d, input bit park_hi);
    send_hdr(1'b0, a, cs);
    for (int k = 0; k < 8; k++) @(negedge clk) lane_i = {d[8+k], d[k]};
    if (park_hi) @(negedge clk) lane_i = 2'b11;
  endtask

  task automatic do_write(input logic a, input logic cs, input logic [15:0] d);
    int wp;
    wp = wr_pulses;
    send_write(a, cs, d, 1'b1);
    repeat (20) @(negedge clk);
    exp_dat = d; exp_fcnt++;
    chk(dat == d, "R2", "write data", dat, d);
    chk(ad == a, "R3", "ad_o", ad, a);
    chk({cs1_n, cs2_n} == {~cs, cs}, "R3", "chip selects", {cs1_n, cs2_n}, {~cs, cs});
    chk(wr_pulses == wp + 1, "R4", "write pulse count", wr_pulses - wp, 1);
    chk(wr_last == STB_CYC, "R4", "write strobe width", wr_last, STB_CYC);
    chk(fcnt == exp_fcnt, "R10", "frame count", fcnt, exp_fcnt);
  endtask

  task automatic do_read(input logic a, input logic cs, input logic i, input logic [15:0] rv);
    int n;
    logic [15:0] got;
    got = '0;
    cur_idr = i; cur_rdata = rv; rd_base = rd_pulses; idr = i;
    send_hdr(1'b1, a, cs);
    @(negedge clk) lane_i = 2'b11;
    n = 1;
    while (!lane_oe && n < 14) begin @(negedge clk); n++; end
    chk(lane_oe && lane_o == 2'b11, "R7", "lanes driven high", {lane_oe, lane_o}, 3'b111);
    n = 0;
    while (!(lane_oe && lane_o[0] == 1'b0) && n < 400) begin @(negedge clk); n++; end
    chk(lane_o == 2'b00, "R8", "start bit", lane_o, 2'b00);
    repeat (LINK_DIV) @(negedge clk);
    for (int k = 0; k < 8; k++) begin
      got[k] = lane_o[0]; got[8+k] = lane_o[1];
      repeat (LINK_DIV) @(negedge clk);
    end
    chk(got == rv, "R8", "returned word", got, rv);
    chk(lane_oe && lane_o == 2'b11, "R9", "tail high", {lane_oe, lane_o}, 3'b111);
    repeat (LINK_DIV) @(negedge clk);
    chk(!lane_oe, "R9", "lanes released", lane_oe, 0);
    exp_fcnt++;
    chk(rd_pulses - rd_base == (i ? 2 : 1), "R6", "read pulse count", rd_pulses - rd_base, i ? 2 : 1);
    chk(rd_last == STB_CYC, "R11", "read strobe width", rd_last, STB_CYC);
    chk(dat == exp_dat, "R5", "data held over read", dat, exp_dat);
    chk(ad == a && {cs1_n, cs2_n} == {~cs, cs}, "R3", "read ad/cs", {ad, cs1_n, cs2_n}, {a, ~cs, cs});
    chk(fcnt == exp_fcnt, "R10", "frame count", fcnt, exp_fcnt);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(dat == 0 && ad && cs1_n && cs2_n && wr_n && rd_n && !lane_oe && fcnt == 0,
        "R1", "reset state", {dat, ad, cs1_n, cs2_n, wr_n, rd_n, lane_oe, fcnt}, {16'h0, 5'b11111, 1'b0, 8'h0});
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      if (VEC[v][19]) do_read(VEC[v][18], VEC[v][17], VEC[v][16], VEC[v][15:0]);
      else            do_write(VEC[v][18], VEC[v][17], VEC[v][15:0]);
    end

    // R5: outputs hold across a long idle
    do_write(1'b1, 1'b1, 16'h3C96);
    repeat (60) @(negedge clk);
    chk(dat == 16'h3C96 && ad && !cs1_n && cs2_n, "R5", "hold after idle",
        {dat, ad, cs1_n, cs2_n}, {16'h3C96, 3'b101});

    // R12: lane 0 held low after a frame must not start a new one
    begin
      int wp;
      wp = wr_pulses;
      send_write(1'b0, 1'b0, 16'h0000, 1'b0);
      repeat (40) @(negedge clk);
      exp_fcnt++;
      chk(fcnt == exp_fcnt, "R12", "no frame on held low", fcnt, exp_fcnt);
      chk(wr_pulses == wp + 1, "R12", "single write pulse", wr_pulses - wp, 1);
      lane_i = 2'b11;
      repeat (4) @(negedge clk);
    end

    // R1: power-down mid read restores idle levels
    cur_idr = 1'b1; cur_rdata = 16'h7777; rd_base = rd_pulses; idr = 1'b1;
    send_hdr(1'b1, 1'b0, 1'b1);
    @(negedge clk) lane_i = 2'b11;
    repeat (5) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(dat == 0 && ad && cs1_n && cs2_n && wr_n && rd_n && !lane_oe && fcnt == 0,
        "R1", "power-down state", {dat, ad, cs1_n, cs2_n, wr_n, rd_n, lane_oe, fcnt},
        {16'h0, 5'b11111, 1'b0, 8'h0});
    finish_run();
  end
endmodule